// File: doc/BRIEF.md
# One-Time Program Memory Programming Port

This block is the programming-side front end of a one-time program memory that stores 10-bit words. It has no address pins. An internal address counter starts from zero when a fixed mode code is applied, and it then advances only on pulses on a separate programming clock pin. Four mode pins pick one operation: clear the address, write, read/verify, or inhibit. An 8-bit data bus carries write data in and read data out. The array is a behavioural model: the erased state is all ones, and programming can only clear bits.

Pulses on the programming clock are grouped in fours. The address moves forward once per group, on the falling edge that ends the third pulse. Because a word is wider than the bus, the position of a pulse inside its group selects which part of the word the bus carries. At count 0 the bus carries the low eight bits. At count 1 it carries the two top bits in bus bits 1..0. The pad-level tri-state is split into an output-enable port, an output-value port and an input-value port. The supply sequencing and the analog pulse widths belong to the surrounding test equipment. The block has no back-pressure: the programming clock sets the pace, and the mode code tells whether the bus is being sampled or driven.

Top module: `otp_prog_port`

## Requirements
- R1: After reset the address and the pulse count are 0, every stored word reads as 10'h3FF, and the bus is released (`bus_oe`=0, `bus_out`=0).
- R2: While mode (bit3..bit0 = MD3..MD0) is 4'b0101, the address and the pulse count are forced to 0 on every clock.
- R3: In any mode other than 4'b0101, each falling edge of `prog_clk` (1 in one `clk` sample and 0 in the next) steps the pulse count 0→1→2→3→0. The address increments by one, wrapping at 1024, on the falling edge that moves the count from 2 to 3.
- R4: While mode is 4'b1110 (write), on each clock the word at the current address is updated. At count 0 its bits 7..0 become themselves AND `bus_in`. At count 1 its bits 9..8 become themselves AND `bus_in[1:0]`. At counts 2 and 3 nothing is written.
- R5: A stored bit that is 0 never returns to 1 except through reset, so writing the same word a second time yields the AND of the two values.
- R6: While mode is 4'b1100 (read/verify), `bus_oe` is 1. At count 1 `bus_out` is {6'b0, word[9:8]}; at every other count it is word[7:0]. The word is the one at the current address.
- R7: In every mode other than 4'b1100, `bus_oe` is 0 and `bus_out` is 0.
- R8: Inhibit codes (4'b1101, 4'b1111) and all undefined codes leave the array unchanged, while `prog_clk` pulses still count.
- R9: At addresses at or above the word count (1002), writes are ignored and reads return the erased pattern 10'h3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| prog_clk | input | 1 | Programming clock; its falling edges advance the pulse count |
| mode | input | 4 | Mode pins, bit 0 = MD0 … bit 3 = MD3 |
| bus_in | input | 8 | Value seen on the data pads |
| bus_out | output | 8 | Value driven onto the data pads when enabled |
| bus_oe | output | 1 | Pad output enable; 0 means high impedance |

## Verification
The assertions assume that `prog_clk` and `mode` are synchronous to `clk`, and that each level of `prog_clk` lasts at least one `clk` cycle, so that a falling edge shows up as one 1-then-0 pair of samples. They also assume the reset is held for at least two clocks, so that the array is fully erased before the word-monotonicity check is enabled. The bench meets these conditions by changing every input only on the falling edge of `clk`, by holding each programming-clock level for exactly one cycle, and by holding reset for three cycles. Its writes pulse the programming clock in inhibit mode between data phases, as a real programmer would. It walks the address past the last word and past the 10-bit wrap.

// File: rtl/otpp_pkg.sv
package otpp_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_CLEAR   = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_INHIBIT = 3'd4
  } prog_op_t;

  // mode bit order: [3]=MD3 [2]=MD2 [1]=MD1 [0]=MD0
  localparam logic [3:0] CODE_CLEAR = 4'b0101;
  localparam logic [3:0] CODE_WRITE = 4'b1110;
  localparam logic [3:0] CODE_READ  = 4'b1100;

endpackage

// File: rtl/otpp_mode_decode.sv
module otpp_mode_decode
  import otpp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  output prog_op_t   op
);

  logic f_clr, f_wr, f_rd, f_inh;

  // Each flag decodes its own code; a code that matches none is OP_NONE.
  assign f_clr = (mode == CODE_CLEAR);
  assign f_wr  = (mode == CODE_WRITE);
  assign f_rd  = (mode == CODE_READ);
  assign f_inh = mode[0] & mode[2] & mode[3];

  always_comb begin
    op = OP_NONE;
    if (f_clr)      op = OP_CLEAR;
    else if (f_wr)  op = OP_WRITE;
    else if (f_rd)  op = OP_READ;
    else if (f_inh) op = OP_INHIBIT;
  end

  // R8: the independently decoded codes never overlap
  assert_codes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({f_clr, f_wr, f_rd, f_inh}));

endmodule

// File: rtl/otpp_addr_seq.sv
module otpp_addr_seq #(
  parameter int ADDR_W    = 10,
  parameter int PHASES    = 4,
  parameter int ADV_PHASE = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       prog_clk,
  input  logic                       clr,
  output logic [ADDR_W-1:0]          addr,
  output logic [$clog2(PHASES)-1:0]  phase
);

  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0] ADV_PH  = PH_W'(ADV_PHASE);

  logic pclk_q;
  logic fall;

  assign fall = pclk_q & ~prog_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= 1'b0;
      addr   <= '0;
      phase  <= '0;
    end else begin
      pclk_q <= prog_clk;
      if (clr) begin
        addr  <= '0;
        phase <= '0;
      end else if (fall) begin
        phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
        if (phase == ADV_PH) addr <= addr + 1'b1;
      end
    end
  end

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr == '0 && phase == '0));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(fall && phase == ADV_PH)) |=> (addr == $past(addr)));

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && fall) |=>
      (phase == (($past(phase) == LAST_PH) ? '0 : $past(phase) + 1'b1)));

endmodule

// File: rtl/otpp_array.sv
module otpp_array #(
  parameter int WORDS  = 1002,
  parameter int WORD_W = 10,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 10,
  parameter int PH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PH_W-1:0]   phase,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [WORD_W-1:0] rd_word
);

  localparam int HI_W = WORD_W - BUS_W;
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(WORDS - 1);
  localparam logic [PH_W-1:0]   LO_PH  = PH_W'(0);
  localparam logic [PH_W-1:0]   HI_PH  = PH_W'(1);

  logic [WORD_W-1:0] cells [WORDS];
  logic in_range;
  logic wr_lo, wr_hi;

  assign in_range = (addr <= LAST_A);
  assign wr_lo    = wr_en & in_range & (phase == LO_PH);
  assign wr_hi    = wr_en & in_range & (phase == HI_PH);
  assign rd_word  = in_range ? cells[addr] : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cells[i] <= '1;
    end else if (wr_lo) begin
      cells[addr][BUS_W-1:0] <= cells[addr][BUS_W-1:0] & bus_in;
    end else if (wr_hi) begin
      cells[addr][WORD_W-1:BUS_W] <= cells[addr][WORD_W-1:BUS_W] & bus_in[HI_W-1:0];
    end
  end

  // R5: at a fixed address no cleared bit comes back
  assert_no_bit_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(addr) |-> ((rd_word & ~$past(rd_word)) == '0));

  // R8: without a write the addressed word does not change
  assert_hold_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!$stable(addr) || $stable(rd_word)));

endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
  import otpp_pkg::*;
#(
  parameter int WORDS     = 1002,
  parameter int WORD_W    = 10,
  parameter int BUS_W     = 8,
  parameter int ADDR_W    = 10,
  parameter int PHASES    = 4,
  parameter int ADV_PHASE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_clk,
  input  logic [3:0]       mode,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe
);

  localparam int PH_W = $clog2(PHASES);
  localparam int HI_W = WORD_W - BUS_W;
  localparam logic [PH_W-1:0] HI_PH = PH_W'(1);

  prog_op_t            op;
  logic [ADDR_W-1:0]   addr;
  logic [PH_W-1:0]     phase;
  logic [WORD_W-1:0]   word;

  otpp_mode_decode i_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (mode),
    .op   (op)
  );

  otpp_addr_seq #(
    .ADDR_W   (ADDR_W),
    .PHASES   (PHASES),
    .ADV_PHASE(ADV_PHASE)
  ) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_clk(prog_clk),
    .clr     (op == OP_CLEAR),
    .addr    (addr),
    .phase   (phase)
  );

  otpp_array #(
    .WORDS (WORDS),
    .WORD_W(WORD_W),
    .BUS_W (BUS_W),
    .ADDR_W(ADDR_W),
    .PH_W  (PH_W)
  ) i_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .phase  (phase),
    .wr_en  (op == OP_WRITE),
    .bus_in (bus_in),
    .rd_word(word)
  );

  always_comb begin
    bus_oe  = (op == OP_READ);
    bus_out = '0;
    if (bus_oe) begin
      if (phase == HI_PH) bus_out = {{(BUS_W-HI_W){1'b0}}, word[WORD_W-1:BUS_W]};
      else                bus_out = word[BUS_W-1:0];
    end
  end

  // R7: a released bus carries no value
  assert_quiet_when_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0));

endmodule

// File: tb/test_otp_prog_port.sv
module test_otp_prog_port;

  localparam int NW = 1002;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_clk = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  otp_prog_port i_otp_prog_port (
    .clk(clk), .rst_n(rst_n), .prog_clk(prog_clk), .mode(mode),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  // behavioural reference model
  logic [9:0] mdl [0:1023];
  int m_addr = 0;
  int m_ph = 0;
  logic m_prev = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mdl[i] = 10'h3FF;
      m_addr = 0; m_ph = 0; m_prev = 1'b0;
    end else begin
      if (mode == 4'b1110 && m_addr < NW) begin
        if (m_ph == 0) mdl[m_addr][7:0] = mdl[m_addr][7:0] & bus_in;
        if (m_ph == 1) mdl[m_addr][9:8] = mdl[m_addr][9:8] & bus_in[1:0];
      end
      if (mode == 4'b0101) begin
        m_addr = 0; m_ph = 0;
      end else if (m_prev && !prog_clk) begin
        if (m_ph == 2) m_addr = (m_addr + 1) % 1024;
        m_ph = (m_ph + 1) % 4;
      end
      m_prev = prog_clk;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance one cycle and compare the ports with the model
  task automatic step();
    logic [9:0] w;
    logic eo;
    logic [7:0] eb;
    @(negedge clk);
    w  = (m_addr < NW) ? mdl[m_addr] : 10'h3FF;
    eo = (mode == 4'b1100);
    eb = !eo ? 8'h00 : (m_ph == 1) ? {6'b0, w[9:8]} : w[7:0];
    chk("R7 bus_oe", int'(bus_oe), int'(eo));
    chk("R6 bus_out", int'(bus_out), int'(eb));
  endtask

  task automatic pulse();
    prog_clk = 1'b1; step();
    prog_clk = 1'b0; step();
  endtask

  task automatic group_pulses(input logic [3:0] m);
    mode = m;
    for (int k = 0; k < 4; k++) pulse();
  endtask

  task automatic write_cur(input logic [7:0] lo, input logic [1:0] hi);
    mode = 4'b1110; bus_in = lo; step();
    mode = 4'b1101; bus_in = 8'h00; pulse();
    mode = 4'b1110; bus_in = {6'h3F, hi}; step();
    mode = 4'b1101; bus_in = 8'h00; pulse(); pulse(); pulse();
  endtask

  task automatic read_cur(output logic [9:0] w);
    mode = 4'b1100; step();
    w[7:0] = bus_out;
    pulse();
    w[9:8] = bus_out[1:0];
    pulse(); pulse(); pulse();
  endtask

  task automatic clear_addr();
    mode = 4'b0101; step(); step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [9:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 reset bus_oe", int'(bus_oe), 0);
    chk("R1 reset bus_out", int'(bus_out), 0);
    read_cur(w);
    chk("R1 erased word", int'(w), 'h3FF);

    // R2: clear returns to address 0 even mid-group
    mode = 4'b1101; pulse();
    clear_addr();
    write_cur(8'hA5, 2'b10);
    write_cur(8'h3C, 2'b01);
    write_cur(8'hFF, 2'b11);
    write_cur(8'h00, 2'b00);
    clear_addr();
    read_cur(w); chk("R4 word0", int'(w), 'h2A5);
    read_cur(w); chk("R4 word1", int'(w), 'h13C);
    read_cur(w); chk("R4 word2", int'(w), 'h3FF);
    read_cur(w); chk("R4 word3", int'(w), 'h000);

    // R5: a second write ANDs into word 0
    clear_addr();
    write_cur(8'h0F, 2'b11);
    clear_addr();
    read_cur(w); chk("R5 and word0", int'(w), 'h205);

    // R8: inhibit and undefined codes with data on the bus change nothing
    clear_addr();
    mode = 4'b1111; bus_in = 8'h00; step(); step();
    mode = 4'b0000; step(); step();
    mode = 4'b0110; step();
    bus_in = 8'h00;
    group_pulses(4'b1101);
    clear_addr();
    read_cur(w); chk("R8 word0 kept", int'(w), 'h205);
    read_cur(w); chk("R8 word1 kept", int'(w), 'h13C);

    // R3: pulses in inhibit step the address; address 1 reached above
    clear_addr();
    group_pulses(4'b1111);
    group_pulses(4'b1111);
    read_cur(w); chk("R3 counted to word2", int'(w), 'h3FF);

    // R9: last word writable, beyond it ignored
    clear_addr();
    for (int g = 0; g < NW - 1; g++) group_pulses(4'b1101);
    write_cur(8'h12, 2'b01);
    write_cur(8'h00, 2'b00);
    clear_addr();
    for (int g = 0; g < NW - 1; g++) group_pulses(4'b1101);
    read_cur(w); chk("R9 last word", int'(w), 'h112);
    read_cur(w); chk("R9 beyond end", int'(w), 'h3FF);

    // R3: the address wraps at 1024 back to word 0
    for (int g = NW + 1; g < 1024; g++) group_pulses(4'b1101);
    read_cur(w); chk("R3 wrap word0", int'(w), 'h205);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule